// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Port

This block is the digital control port of a two-channel 16-bit digital-to-analog converter. A host frames each transfer by pulling the chip-select/load line low, shifts a command word in on the serial data input with the serial clock, and raises chip-select/load to execute it. Each channel keeps a code input register and a span input register. The code and span values that actually drive the converter sit in a second pair of registers per channel. That second pair loads from the input registers only on an update command or on a pulse of the asynchronous load input. Both halves of a channel therefore change on the same cycle.

A frame carries a 4-bit operation, a 4-bit address and a 16-bit data word, MSB first. The frame is either 24 bits long or 32 bits long. In the 32-bit form, eight padding bits come before the 24 meaningful ones. While a frame is being clocked in, the serial readback output returns the 16-bit input register value that the previous accepted write or read command touched. The host can therefore confirm a staged value before it commits that value with an update.

All serial and load inputs are synchronised into the system clock domain, and their edges are detected there. The serial clock must therefore run well below the system clock. The converter-side code and span values are registered parallel outputs.

Top module: `dual_dac_serial_port`

## Requirements
- R1: After synchronous reset, every input register, every DAC code and span output, and the readback echo value are zero, and `sro` is low.
- R2: A valid frame with operation 0011 loads its data word into the code input register of the addressed channel. `dac_code` does not change as a result.
- R3: A valid frame with operation 0010 loads the low SPAN_W bits of its data word into the span input register of the addressed channel. `dac_span` does not change as a result.
- R4: A frame of exactly 32 bits acts the same as the 24-bit frame made of its last 24 bits. The first 8 bits have no effect.
- R5: Operation 0100 copies both input registers of each addressed channel into that channel's DAC code and span outputs. Channels that are not addressed keep their outputs, and the data field is ignored.
- R6: Channel k answers to address 2k (A = 0000, B = 0010). Address 1111 applies write and update operations to every channel.
- R7: A falling edge on `dac_load_n` copies the input registers of all channels into the DAC outputs, without any frame.
- R8: A frame whose SCK rising-edge count is neither 24 nor 32 changes no register, including the readback echo.
- R9: A frame with an operation other than 0010, 0011, 0100 or 1010, or with an address that selects no channel, changes no register.
- R10: From the falling edge of chip-select/load, `sro` presents the echo value MSB first. It advances one bit on each SCK falling edge, so bit 15-i is valid at the (i+1)-th SCK rise. Zeros follow after bit 0.
- R11: The echo value becomes the data word written by operation 0011, or the zero-extended span written by operation 0010. Operation 1010 sets it to the zero-extended span input register of the addressed channel, or of channel A for address 1111. Update operations leave it unchanged.
- R12: `sro` is low whenever chip-select/load is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock; SDI is sampled on its rising edge |
| sdi | input | 1 | Serial command data, MSB first |
| cs_ld | input | 1 | Frame select, low during a frame; the command executes on its rising edge |
| dac_load_n | input | 1 | Asynchronous load; a falling edge updates every channel |
| sro | output | 1 | Serial readback of the echo value |
| dac_code | output | NUM_CH*16 | DAC code per channel, channel k at bits [16k+15:16k] |
| dac_span | output | NUM_CH*SPAN_W | DAC span per channel, channel k at bits [SPAN_W*k+SPAN_W-1:SPAN_W*k] |

## Verification
The hardest state to reach is one where the input registers and the DAC outputs of a channel disagree in code and span at the same time, while the echo still holds a value from an earlier command. Only in that state does a faulty update or a stray echo change become visible at the ports. The stimulus reaches it by mixing frames of random operation, address and length, including lengths one short or one over the valid ones. It inserts load pulses at random points, so staged and committed values keep drifting apart. Directed sequences read a staged span back before committing it and then use the all-channels address.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int DATA_W = 16;
  localparam int OP_W   = 4;
  localparam int ADDR_W = 4;
  localparam int CMD_W  = OP_W + ADDR_W + DATA_W;

  localparam logic [OP_W-1:0] OP_SPAN_WR = 4'b0010;
  localparam logic [OP_W-1:0] OP_CODE_WR = 4'b0011;
  localparam logic [OP_W-1:0] OP_UPDATE  = 4'b0100;
  localparam logic [OP_W-1:0] OP_SPAN_RD = 4'b1010;

  localparam logic [ADDR_W-1:0] ADDR_ALL = 4'hF;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic logic [ADDR_W-1:0] ch_addr(input int k);
    return ADDR_W'(2 * k);
  endfunction
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int N = 1,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl
);
  logic [N-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= INIT;
      lvl  <= INIT;
    end else begin
      meta <= din;
      lvl  <= meta;
    end
  end
endmodule

// File: rtl/dacif_edge.sv
module dacif_edge #(
  parameter int N = 1,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] prev
);
  always_ff @(posedge clk) begin
    if (rst) prev <= INIT;
    else     prev <= lvl;
  end
endmodule

// File: rtl/dacif_rx.sv
module dacif_rx
  import dacif_pkg::*;
#(
  parameter int FRAME_SHORT = 24,
  parameter int FRAME_LONG  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_lvl,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic sck_rise,
  input  logic sdi_lvl,
  output logic cmd_stb,
  output cmd_t cmd
);
  localparam int CNT_MAX = FRAME_LONG + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CMD_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic             len_ok;

  assign len_ok = (cnt == CNT_W'(FRAME_SHORT)) || (cnt == CNT_W'(FRAME_LONG));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      cnt     <= '0;
      cmd_stb <= 1'b0;
      cmd     <= '0;
    end else begin
      cmd_stb <= 1'b0;
      if (cs_fall) begin
        cnt <= '0;
      end else if (!cs_lvl && sck_rise) begin
        shreg <= {shreg[CMD_W-2:0], sdi_lvl};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
      if (cs_rise && len_ok) begin
        cmd_stb <= 1'b1;
        cmd     <= cmd_t'(shreg);
      end
    end
  end

  // R8
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> $past(cs_rise));
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
  import dacif_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int SPAN_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_stb,
  input  cmd_t cmd,
  input  logic load_all,
  output logic [NUM_CH-1:0][DATA_W-1:0] dac_code,
  output logic [NUM_CH-1:0][SPAN_W-1:0] dac_span,
  output logic [DATA_W-1:0] echo
);
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0][DATA_W-1:0] in_code;
  logic [NUM_CH-1:0][SPAN_W-1:0] in_span;
  logic [NUM_CH-1:0] hit;
  logic              any_hit;
  logic [SEL_W-1:0]  first;
  logic wr_code, wr_span, rd_span, upd;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
    assign hit[k] = (cmd.addr == ADDR_ALL) || (cmd.addr == ch_addr(k));
  end

  assign any_hit = |hit;

  always_comb begin
    first = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (hit[k]) first = SEL_W'(k);
    end
  end

  assign wr_code = cmd_stb && any_hit && (cmd.op == OP_CODE_WR);
  assign wr_span = cmd_stb && any_hit && (cmd.op == OP_SPAN_WR);
  assign rd_span = cmd_stb && any_hit && (cmd.op == OP_SPAN_RD);
  assign upd     = cmd_stb && any_hit && (cmd.op == OP_UPDATE);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_code  <= '0;
      in_span  <= '0;
      dac_code <= '0;
      dac_span <= '0;
      echo     <= '0;
    end else begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (wr_code && hit[k]) in_code[k] <= cmd.data;
        if (wr_span && hit[k]) in_span[k] <= cmd.data[SPAN_W-1:0];
        if (load_all || (upd && hit[k])) begin
          dac_code[k] <= in_code[k];
          dac_span[k] <= in_span[k];
        end
      end
      if (wr_code)      echo <= cmd.data;
      else if (wr_span) echo <= {{(DATA_W-SPAN_W){1'b0}}, cmd.data[SPAN_W-1:0]};
      else if (rd_span) echo <= {{(DATA_W-SPAN_W){1'b0}}, in_span[first]};
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dac_code == '0 && dac_span == '0 && echo == '0));

  // R2
  input_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_stb |=> ($stable(in_code) && $stable(in_span)));

  // R5
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(upd || load_all) |=> ($stable(dac_code) && $stable(dac_span)));

  // R9
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && !any_hit) |=> ($stable(in_code) && $stable(in_span) && $stable(echo)));
endmodule

// File: rtl/dacif_tx.sv
module dacif_tx
  import dacif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] echo,
  output logic              sro
);
  logic [DATA_W-1:0] txreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      txreg <= '0;
      sro   <= 1'b0;
    end else if (cs_fall) begin
      sro   <= echo[DATA_W-1];
      txreg <= {echo[DATA_W-2:0], 1'b0};
    end else if (cs_lvl) begin
      sro   <= 1'b0;
      txreg <= '0;
    end else if (sck_fall) begin
      sro   <= txreg[DATA_W-1];
      txreg <= {txreg[DATA_W-2:0], 1'b0};
    end
  end

  // R12
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> !sro);
endmodule

// File: rtl/dual_dac_serial_port.sv
module dual_dac_serial_port
  import dacif_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SPAN_W      = 4,
  parameter int FRAME_SHORT = 24,
  parameter int FRAME_LONG  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sck,
  input  logic                       sdi,
  input  logic                       cs_ld,
  input  logic                       dac_load_n,
  output logic                       sro,
  output logic [NUM_CH*DATA_W-1:0]   dac_code,
  output logic [NUM_CH*SPAN_W-1:0]   dac_span
);
  // bit order of the synchronised group: {sdi, dac_load_n, sck, cs_ld}
  logic [3:0] lvl;
  logic [2:0] prev;
  logic cs_lvl, cs_fall, cs_rise, sck_rise, sck_fall, load_fall;
  logic cmd_stb;
  cmd_t cmd;
  logic [NUM_CH-1:0][DATA_W-1:0] code_arr;
  logic [NUM_CH-1:0][SPAN_W-1:0] span_arr;
  logic [DATA_W-1:0] echo;

  dacif_sync #(.N(4), .INIT(4'b0101)) u_sync (
    .clk(clk), .rst(rst), .din({sdi, dac_load_n, sck, cs_ld}), .lvl(lvl)
  );

  dacif_edge #(.N(3), .INIT(3'b101)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl[2:0]), .prev(prev)
  );

  assign cs_lvl    = lvl[0];
  assign cs_fall   = !lvl[0] &&  prev[0];
  assign cs_rise   =  lvl[0] && !prev[0];
  assign sck_rise  =  lvl[1] && !prev[1];
  assign sck_fall  = !lvl[1] &&  prev[1];
  assign load_fall = !lvl[2] &&  prev[2];

  dacif_rx #(.FRAME_SHORT(FRAME_SHORT), .FRAME_LONG(FRAME_LONG)) u_rx (
    .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sdi_lvl(lvl[3]), .cmd_stb(cmd_stb), .cmd(cmd)
  );

  dacif_regs #(.NUM_CH(NUM_CH), .SPAN_W(SPAN_W)) u_regs (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd(cmd), .load_all(load_fall),
    .dac_code(code_arr), .dac_span(span_arr), .echo(echo)
  );

  dacif_tx u_tx (
    .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .cs_fall(cs_fall),
    .sck_fall(sck_fall), .echo(echo), .sro(sro)
  );

  assign dac_code = code_arr;
  assign dac_span = span_arr;
endmodule

// File: tb/dual_dac_serial_port_test.sv
module dual_dac_serial_port_test;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, sdi = 1'b0, cs_ld = 1'b1, dac_load_n = 1'b1;
  logic sro;
  logic [31:0] dac_code;
  logic [7:0]  dac_span;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [15:0] m_code [2];
  logic [3:0]  m_span [2];
  logic [15:0] m_dcode [2];
  logic [3:0]  m_dspan [2];
  logic [15:0] m_echo;

  dual_dac_serial_port uut (
    .clk(clk), .rst(rst), .sck(sck), .sdi(sdi), .cs_ld(cs_ld),
    .dac_load_n(dac_load_n), .sro(sro), .dac_code(dac_code), .dac_span(dac_span)
  );

  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " dac_code"}, dac_code, {m_dcode[1], m_dcode[0]});
    chk({tag, " dac_span"}, {24'h0, dac_span}, {24'h0, m_dspan[1], m_dspan[0]});
    chk({tag, " R12 sro idle"}, {31'h0, sro}, 32'h0);
  endtask

  function automatic void model_exec(input int nbits, input logic [31:0] w);
    logic [3:0] op, addr;
    logic [15:0] d;
    logic [1:0] hit;
    if (nbits != 24 && nbits != 32) return;
    op = w[23:20]; addr = w[19:16]; d = w[15:0];
    for (int k = 0; k < 2; k++) hit[k] = (addr == 4'hF) || (addr == 4'(2 * k));
    if (hit == 2'b00) return;
    case (op)
      4'b0011: begin
        for (int k = 0; k < 2; k++) if (hit[k]) m_code[k] = d;
        m_echo = d;
      end
      4'b0010: begin
        for (int k = 0; k < 2; k++) if (hit[k]) m_span[k] = d[3:0];
        m_echo = {12'h0, d[3:0]};
      end
      4'b0100: begin
        for (int k = 0; k < 2; k++) if (hit[k]) begin
          m_dcode[k] = m_code[k]; m_dspan[k] = m_span[k];
        end
      end
      4'b1010: m_echo = {12'h0, hit[0] ? m_span[0] : m_span[1]};
      default: ;
    endcase
  endfunction

  task automatic send_frame(input int nbits, input logic [31:0] w, output logic [15:0] rb);
    rb = '0;
    cs_ld = 1'b0;
    tick(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = w[i];
      tick(HALF);
      if (nbits - 1 - i < 16) rb[15 - (nbits - 1 - i)] = sro;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
    cs_ld = 1'b1;
    tick(10);
  endtask

  task automatic do_frame(input int nbits, input logic [31:0] w, input string tag,
                          output logic [15:0] rb);
    logic [15:0] exp_rb;
    exp_rb = m_echo;
    send_frame(nbits, w, rb);
    if (nbits >= 16) chk({tag, " R10/R11 readback"}, {16'h0, rb}, {16'h0, exp_rb});
    model_exec(nbits, w);
    check_outs(tag);
  endtask

  task automatic load_pulse();
    dac_load_n = 1'b0;
    tick(4);
    dac_load_n = 1'b1;
    tick(8);
    for (int k = 0; k < 2; k++) begin
      m_dcode[k] = m_code[k]; m_dspan[k] = m_span[k];
    end
    check_outs("R7 load pulse");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, all requirements unverified");
    summary();
  end

  initial begin
    logic [15:0] rb;
    int lens [8];
    void'($urandom(32'd20250611));
    lens = '{24, 32, 24, 32, 16, 23, 31, 33};
    for (int k = 0; k < 2; k++) begin
      m_code[k] = '0; m_span[k] = '0; m_dcode[k] = '0; m_dspan[k] = '0;
    end
    m_echo = '0;
    tick(6);
    rst = 1'b0;
    tick(6);
    check_outs("R1 reset");

    // staged code and span on channel B, read back before committing
    do_frame(32, 32'hA5328000, "R4 R2 code B", rb);
    chk("R2 dac unchanged", dac_code, 32'h0);
    do_frame(32, 32'h00220004, "R4 R3 span B", rb);
    chk("R11 echo of code write", {16'h0, rb}, 32'h8000);
    do_frame(32, 32'h00A2BEEF, "R11 span read B", rb);
    chk("R11 echo of span write", {16'h0, rb}, 32'h0004);
    do_frame(24, 32'h0042FFFF, "R5 update B", rb);
    chk("R5 code B only", dac_code, 32'h8000_0000);
    chk("R5 span B only", {24'h0, dac_span}, 32'h40);
    do_frame(20, 32'h00301234, "R8 short frame", rb);
    chk("R11 echo kept by update", {16'h0, rb}, 32'h0004);
    do_frame(25, 32'h00301234, "R8 long frame", rb);
    do_frame(24, 32'h00000000, "R8 probe", rb);
    chk("R8 echo unchanged", {16'h0, rb}, 32'h0004);

    // all-channels address then asynchronous load
    do_frame(24, 32'h002F0003, "R6 span all", rb);
    do_frame(24, 32'h00200001, "R3 span A", rb);
    do_frame(24, 32'h003F8000, "R6 code all", rb);
    do_frame(24, 32'h00300000, "R2 code A", rb);
    load_pulse();
    chk("R7 codes", dac_code, 32'h8000_0000);
    chk("R7 spans", {24'h0, dac_span}, 32'h31);

    // ignored commands
    do_frame(24, 32'h0070AAAA, "R9 unknown op", rb);
    do_frame(24, 32'h0035AAAA, "R9 unused addr", rb);
    do_frame(24, 32'h004F0000, "R9 R6 update all", rb);
    do_frame(24, 32'h00AF0000, "R11 read all", rb);
    chk("R9 echo after ignored", {16'h0, rb}, 32'h0000);

    for (int n = 0; n < 120; n++) begin
      int len;
      logic [3:0] op, addr;
      logic [31:0] w;
      len = lens[$urandom % 8];
      case ($urandom % 6)
        0: op = 4'b0010;
        1: op = 4'b0011;
        2: op = 4'b0100;
        3: op = 4'b1010;
        4: op = 4'($urandom);
        default: op = 4'b0011;
      endcase
      case ($urandom % 5)
        0: addr = 4'h0;
        1: addr = 4'h2;
        2: addr = 4'hF;
        3: addr = 4'($urandom);
        default: addr = 4'h2;
      endcase
      w = {8'($urandom), op, addr, 16'($urandom)};
      do_frame(len, w, "R2/R3/R5/R8/R9 random", rb);
      if ($urandom % 8 == 0) load_pulse();
    end

    summary();
  end
endmodule